// File: doc/BRIEF.md
# CPU Clock Divider and Supply-Monitor Enable Register

This block holds an 8-bit read/write oscillator control register and turns its contents into two timing outputs. A 3-bit speed field picks how many base-clock cycles pass between CPU clock-enable pulses. The base clock is nominally 24 MHz, from either the internal oscillator or an external input. At reset the divider runs at one eighth of the base rate. The CPU logic advances only on cycles where the enable is high. The divide-ratio table is deliberately not monotonic in the code value.

A single override bit and the sleep indication together decide when the supply-monitor circuit is powered. While the chip is awake the monitor stays on. During sleep it follows an externally generated duty-cycle pulse, unless the override bit keeps it on continuously. A 2-bit sleep-interval field is stored for a separate timer and has no influence on the monitor enable.

Top module: `cpuclk_ctrl`

## Requirements
- R1: After synchronous reset the register reads 8'h00, the monitor enable is 1 and the CPU enable period is 8 base cycles, with the first pulse in the first cycle after reset is released.
- R2: A write stores bits [5:0] of the write data on the next clock edge. Readback shows them unchanged. Without a write the register holds its value.
- R3: Bits [7:6] ignore written values and always read as 0.
- R4: The speed code is bits [2:0]. The divide ratios are: 000 gives /8, 001 gives /4, 010 gives /2, 011 gives /1, 100 gives /16, 101 gives /32 and 110 gives /128.
- R5: Speed code 111 divides by 8 and reads back as 111.
- R6: The CPU enable is one cycle wide and repeats every N base cycles for ratio N. At ratio 1 it is high on every cycle.
- R7: A new ratio is adopted only when the current period ends, so the period during which a write occurs keeps its old length.
- R8: While sleep is high and bit 5 (override) is 0, the monitor enable equals the duty-cycle pulse input from one cycle earlier.
- R9: While sleep is high and bit 5 is 1, the monitor enable is 1 in the next cycle whatever the duty pulse does.
- R10: While sleep is low, the monitor enable is 1 in the next cycle.
- R11: The sleep-interval field, bits [4:3], has no effect on the monitor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (24 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| sleep_i | input | 1 | Chip is in sleep |
| duty_pulse_i | input | 1 | Periodic monitor duty-cycle pulse |
| rd_data | output | 8 | Register readback |
| cpu_ce | output | 1 | One-cycle CPU clock enable |
| mon_en | output | 1 | Supply-monitor enable |

## Verification
All eight speed codes are written in turn, and the gap between consecutive enable pulses is measured once the change has settled. This separates the non-monotonic mappings from one another and from the reserved code's fallback to /8. A write made in the middle of a /8 period checks that the running period completes at the old length before /1 takes over. The monitor enable is checked in three situations: awake, asleep with the override clear (duty pulse both high and low, with the interval field both zero and non-zero), and asleep with the override set. Together these separate the three sources of the enable.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
    localparam int CTRL_W = 8;
    localparam int SPD_W  = 3;
    localparam int CNT_W  = 7;
    localparam int NOBUZZ_BIT = 5;
    localparam logic [CTRL_W-1:0] WR_MASK = 8'h3F;

    // reload value (ratio - 1) for a given speed code
    function automatic logic [CNT_W-1:0] reload_of(input logic [SPD_W-1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            3'b000:  r = 7'd7;
            3'b001:  r = 7'd3;
            3'b010:  r = 7'd1;
            3'b011:  r = 7'd0;
            3'b100:  r = 7'd15;
            3'b101:  r = 7'd31;
            3'b110:  r = 7'd127;
            default: r = 7'd7;
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } reg_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    typedef struct packed {
        logic en;
    } mon_state_t;
endpackage

// File: rtl/cpuclk_reg.sv
module cpuclk_reg
    import cpuclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_o
);
    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = wr_data & WR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
endmodule

// File: rtl/cpuclk_div.sv
module cpuclk_div
    import cpuclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SPD_W-1:0] speed_i,
    output logic             ce_o
);
    div_state_t st_d, st_q;
    logic       at_edge;

    always_comb begin
        st_d    = st_q;
        at_edge = (st_q.cnt == '0);
        if (at_edge) begin
            st_d.cnt = reload_of(speed_i);
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ce_o = at_edge;
endmodule

// File: rtl/cpuclk_mon.sv
module cpuclk_mon (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    input  logic nobuzz_i,
    input  logic duty_i,
    output logic en_o
);
    import cpuclk_pkg::*;
    mon_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = !sleep_i || nobuzz_i || duty_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{en: 1'b1};
        else     st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
    import cpuclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              sleep_i,
    input  logic              duty_pulse_i,
    output logic [CTRL_W-1:0] rd_data,
    output logic              cpu_ce,
    output logic              mon_en
);
    logic [CTRL_W-1:0] ctrl_w;

    cpuclk_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl_w)
    );

    cpuclk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .speed_i (ctrl_w[SPD_W-1:0]),
        .ce_o    (cpu_ce)
    );

    cpuclk_mon u_mon (
        .clk      (clk),
        .rst      (rst),
        .sleep_i  (sleep_i),
        .nobuzz_i (ctrl_w[NOBUZZ_BIT]),
        .duty_i   (duty_pulse_i),
        .en_o     (mon_en)
    );

    assign rd_data = ctrl_w;
endmodule

// File: rtl/cpuclk_ctrl_chk.sv
module cpuclk_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       sleep_i,
    input logic       duty_pulse_i,
    input logic [7:0] rd_data,
    input logic       cpu_ce,
    input logic       mon_en
);
    logic [7:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)         gap_q <= '0;
        else if (cpu_ce) gap_q <= '0;
        else             gap_q <= gap_q + 1'b1;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b00); // R3
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == ($past(wr_data) & 8'h3F)); // R2
    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data)); // R2
    AST_AWAKE_MON: assert property (@(posedge clk) disable iff (rst)
        !sleep_i |=> mon_en); // R10
    AST_OVERRIDE_MON: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && rd_data[5]) |=> mon_en); // R9
    AST_DUTY_MON: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && !rd_data[5]) |=> (mon_en == $past(duty_pulse_i))); // R8
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        gap_q < 8'd128); // R6
endmodule

bind cpuclk_ctrl cpuclk_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sleep_i      (sleep_i),
    .duty_pulse_i (duty_pulse_i),
    .rd_data      (rd_data),
    .cpu_ce       (cpu_ce),
    .mon_en       (mon_en)
);

// File: tb/cpuclk_ctrl_tb_top.sv
module cpuclk_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sleep_i = 1'b0;
    logic       duty_pulse_i = 1'b0;
    logic [7:0] rd_data;
    logic       cpu_ce;
    logic       mon_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cpuclk_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .sleep_i      (sleep_i),
        .duty_pulse_i (duty_pulse_i),
        .rd_data      (rd_data),
        .cpu_ce       (cpu_ce),
        .mon_en       (mon_en)
    );

    // speed code vectors (R4, R5): written value, expected readback, expected ratio
    localparam logic [7:0] VEC_WR [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'hC7};
    localparam logic [7:0] VEC_RD [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
    localparam int         VEC_N  [8] = '{8, 4, 2, 1, 16, 32, 128, 8};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // cycles until the next sampled cpu_ce pulse
    task automatic next_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ce && n < 1000);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1;
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 readback", int'(rd_data), 0);
        check("R1 mon_en", int'(mon_en), 1);
        check("R1 first pulse", int'(cpu_ce), 1);
        next_pulse(g);
        check("R1 default period", g, 8);

        // R4 R5 R6: vector table walk
        for (int i = 0; i < 8; i++) begin
            write_reg(VEC_WR[i]);
            check("R2/R3/R5 readback", int'(rd_data), int'(VEC_RD[i]));
            next_pulse(g);
            next_pulse(g);
            next_pulse(g);
            check("R4/R5/R6 period", g, VEC_N[i]);
            if (VEC_N[i] == 1) begin
                @(negedge clk);
                check("R6 ratio1 continuous", int'(cpu_ce), 1);
            end
        end

        // R3: reserved bits ignore writes
        write_reg(8'hFF);
        check("R3 reserved read 0", int'(rd_data), 8'h3F);
        // R2: holds without write
        repeat (5) @(negedge clk);
        check("R2 hold", int'(rd_data), 8'h3F);

        // R7: mid-period change keeps old period
        write_reg(8'h00);
        next_pulse(g);
        next_pulse(g);
        repeat (2) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h03;
        @(negedge clk);
        wr_en = 1'b0;
        next_pulse(g);
        check("R7 old period kept", g + 3, 8);
        next_pulse(g);
        check("R7 new period", g, 1);

        // R10: awake keeps monitor on even with duty low
        write_reg(8'h00);
        sleep_i = 1'b0;
        duty_pulse_i = 1'b0;
        @(negedge clk);
        check("R10 awake mon", int'(mon_en), 1);

        // R8: sleep, override clear, follow duty
        sleep_i = 1'b1;
        @(negedge clk);
        check("R8 duty low", int'(mon_en), 0);
        duty_pulse_i = 1'b1;
        @(negedge clk);
        check("R8 duty high", int'(mon_en), 1);
        duty_pulse_i = 1'b0;
        @(negedge clk);
        check("R8 duty back low", int'(mon_en), 0);

        // R11: interval field no effect
        write_reg(8'h18);
        @(negedge clk);
        check("R11 interval, duty low", int'(mon_en), 0);
        duty_pulse_i = 1'b1;
        @(negedge clk);
        check("R11 interval, duty high", int'(mon_en), 1);
        duty_pulse_i = 1'b0;

        // R9: override keeps monitor on
        write_reg(8'h20);
        @(negedge clk);
        check("R9 override", int'(mon_en), 1);
        repeat (4) @(negedge clk);
        check("R9 override sustained", int'(mon_en), 1);

        // R1: reset again clears register
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset readback", int'(rd_data), 0);
        sleep_i = 1'b0;
        finish_run();
    end
endmodule